// File: doc/BRIEF.md
# Bus Master Standby Controller

This block sits between the inbound side of a link controller and the initiator port it owns on a system interconnect. It drives the master-side standby handshake. `mstandby` tells the system whether inbound traffic can reach the initiator port. `mwait` comes back from the system and closes the port until the path to memory is open again. `mwakeup` tells the system that a request is parked while the master is in standby. A two-bit mode register, written through a simple write port, picks one of three behaviours: standby held on, standby held off, or smart standby. In smart standby, the master leaves standby only while the function is in power state D0-active and its memory-space enable is set.

The smart decision depends on whether transactions are possible, not on actual traffic. Active-state link power states (L0s, L1) do not move `mstandby`, and neither does a request that arrives. Inbound requests enter through a valid/ready stream and are held in a single-entry slot. The slot offers its request on the master stream only while `mstandby` is 0 and `mwait` is 0. A request that is already offered stays offered until it is taken. `mstandby` cannot rise while a request is outstanding on the master port.

Back-pressure rules: the inbound side may present a beat only while `in_ready` is 1. `in_ready` is 1 when the slot is empty, or when the slot drains in the same cycle. The link cannot in general be stalled, so a beat presented while `in_ready` is 0 is dropped, and `ovf_err` pulses. On the master side, `m_valid` and `m_data` stay stable until `m_ready` is seen high.

Top module: `mstby_ctrl`

## Requirements
- R1: After reset, `mstandby` is 1, the mode is smart standby, `m_valid`, `mwakeup` and `ovf_err` are 0, and `in_ready` is 1.
- R2: A write on the mode port takes effect at the clock edge where `cfg_wr_en` is sampled high, and `mstandby` follows at the next edge. Code 0 forces `mstandby` to 1. Code 1 holds it at 0. Code 2 selects smart standby. Code 3 behaves exactly like code 2.
- R3: In smart standby, `mstandby` is 0 exactly when `pwr_state` is 0 (D0-active) and `mem_en` is 1. The other power codes are 1 = D1, 2 = D2 and 3 = D3hot, and any of them, or a cleared `mem_en`, gives 1. A change shows on `mstandby` one clock edge after the inputs change.
- R4: `link_pm` has no effect on `mstandby`. Its codes are 0 = L0, 1 = L0s, 2 = L1 and 3 = L2.
- R5: An inbound request never changes `mstandby`. `mwakeup` is 1 exactly while a request is held and `mstandby` is 1.
- R6: `m_valid` is 0 while `mstandby` is 1. A new offer starts only while `mwait` is 0. A held request is delivered with its data unchanged once both signals are 0.
- R7: A beat presented while `in_ready` is 0 is dropped, and `ovf_err` is 1 for the one cycle after it. The held request is not disturbed.
- R8: `mstandby` does not rise while `m_valid` is 1. It rises at the earliest on the edge after the outstanding request is accepted.
- R9: When the slot is drained (`m_valid` and `m_ready` both 1), `in_ready` is 1 in the same cycle, so that a new beat can refill the slot at that edge.
- R10: Once `m_valid` is 1 with `m_ready` 0, `m_valid` stays 1 and `m_data` stays stable at the next edge. Requests leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 2 | Mode code to write |
| pwr_state | input | PS_W | Function power state (0 = D0-active) |
| mem_en | input | 1 | Memory-space enable |
| link_pm | input | 2 | Link power-management state |
| in_valid | input | 1 | Inbound request valid |
| in_ready | output | 1 | Slot can take an inbound request |
| in_data | input | DATA_W | Inbound request payload |
| m_valid | output | 1 | Request offered on master port |
| m_ready | input | 1 | Interconnect accepts request |
| m_data | output | DATA_W | Master port payload |
| mstandby | output | 1 | Master standby status |
| mwait | input | 1 | System not yet ready for the master |
| mwakeup | output | 1 | Request parked while in standby |
| ovf_err | output | 1 | One-cycle pulse on a dropped inbound beat |

## Verification
The smart decision is swept over all eight pairs of power code and enable, and then over random combinations. Link states are varied on their own, which separates a decision taken on the power state from one that follows link activity. Each mode code is written against conditions where smart standby would give the opposite answer, so a wrong decode of force, none, or the reserved code shows up. The directed gating sequence parks a request in standby, overflows the slot, releases `mwait` late and clears the enable while a request is outstanding. This separates the gate on `mstandby` from the gate on `mwait`, and it catches standby rising too early. Random traffic with random `m_ready` in no-standby mode checks ordering, hold stability and same-cycle refill.

// File: rtl/mstby_pkg.sv
package mstby_pkg;

  typedef enum logic [1:0] {
    MODE_FORCE = 2'd0,
    MODE_NONE  = 2'd1,
    MODE_SMART = 2'd2,
    MODE_RSVD  = 2'd3
  } stby_mode_e;

  localparam int unsigned PS_W_DEF = 2;
  localparam logic [PS_W_DEF-1:0] PS_D0_ACTIVE = '0;

endpackage

// File: rtl/mstby_mode_reg.sv
module mstby_mode_reg
  import mstby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output stby_mode_e mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_SMART;
    end else if (wr_en) begin
      mode_q <= stby_mode_e'(wr_data);
    end
  end

endmodule

// File: rtl/mstby_decide.sv
module mstby_decide
  import mstby_pkg::*;
#(
  parameter int unsigned PS_W = PS_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  stby_mode_e      mode,
  input  logic [PS_W-1:0] pwr_state,
  input  logic            mem_en,
  input  logic            outstanding,
  output logic            mstandby_q
);

  localparam logic [PS_W-1:0] D0_CODE = PS_W'(PS_D0_ACTIVE);

  logic access_possible;
  logic want_stby;
  logic stby_next;

  assign access_possible = (pwr_state == D0_CODE) && mem_en;

  always_comb begin
    unique case (mode)
      MODE_FORCE: want_stby = 1'b1;
      MODE_NONE:  want_stby = 1'b0;
      default:    want_stby = !access_possible;
    endcase
  end

  // leaving standby is immediate; re-entry waits for the port to be idle
  assign stby_next = want_stby && (mstandby_q || !outstanding);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstandby_q <= 1'b1;
    end else begin
      mstandby_q <= stby_next;
    end
  end

endmodule

// File: rtl/mstby_slot.sv
module mstby_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_open,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              held,
  output logic              ovf_q
);

  logic              slot_v;
  logic [DATA_W-1:0] slot_d;
  logic              offer_q;
  logic              m_fire;
  logic              in_fire;

  assign m_valid  = slot_v && (gate_open || offer_q);
  assign m_data   = slot_d;
  assign m_fire   = m_valid && m_ready;
  assign in_ready = !slot_v || m_fire;
  assign in_fire  = in_valid && in_ready;
  assign held     = slot_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_v  <= 1'b0;
      offer_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (in_fire) begin
        slot_v <= 1'b1;
      end else if (m_fire) begin
        slot_v <= 1'b0;
      end
      offer_q <= m_valid && !m_ready;
      ovf_q   <= in_valid && !in_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      slot_d <= in_data;
    end
  end

endmodule

// File: rtl/mstby_ctrl.sv
module mstby_ctrl
  import mstby_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PS_W   = PS_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_data,
  input  logic [PS_W-1:0]   pwr_state,
  input  logic              mem_en,
  input  logic [1:0]        link_pm,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              mstandby,
  input  logic              mwait,
  output logic              mwakeup,
  output logic              ovf_err
);

  stby_mode_e mode_w;
  logic       stby_w;
  logic       held_w;
  logic       gate_w;

  mstby_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .mode_q  (mode_w)
  );

  mstby_decide #(.PS_W(PS_W)) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_w),
    .pwr_state   (pwr_state),
    .mem_en      (mem_en),
    .outstanding (m_valid),
    .mstandby_q  (stby_w)
  );

  assign gate_w = !stby_w && !mwait;

  mstby_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_open (gate_w),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .held      (held_w),
    .ovf_q     (ovf_err)
  );

  assign mstandby = stby_w;
  assign mwakeup  = held_w && stby_w;

endmodule

// File: rtl/mstby_ctrl_chk.sv
module mstby_ctrl_chk
  import mstby_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PS_W   = PS_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_code,
  input logic [PS_W-1:0]   pwr_state,
  input logic              mem_en,
  input logic [1:0]        link_pm,
  input logic              in_valid,
  input logic              in_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic              mstandby,
  input logic              mwait,
  input logic              mwakeup,
  input logic              ovf_err
);

  logic seen_edge;
  logic smart_low_link;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  assign smart_low_link = mode_code[1] && (pwr_state == PS_W'(PS_D0_ACTIVE)) && mem_en
                          && (link_pm != 2'd0);

  AST_GATE_ON_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !mstandby); // R6

  AST_OFFER_NEEDS_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> !mwait); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R10

  AST_NO_RISE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mstandby) |-> !$past(m_valid)); // R8

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> ovf_err); // R7

  AST_WAKE_ONLY_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    mwakeup |-> mstandby); // R5

  AST_LINK_STATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $past(smart_low_link)) |-> !mstandby); // R4

endmodule

bind mstby_ctrl mstby_ctrl_chk #(.DATA_W(DATA_W), .PS_W(PS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_code (mode_w),
  .pwr_state (pwr_state),
  .mem_en    (mem_en),
  .link_pm   (link_pm),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .mstandby  (mstandby),
  .mwait     (mwait),
  .mwakeup   (mwakeup),
  .ovf_err   (ovf_err)
);

// File: tb/mstby_ctrl_test.sv
module mstby_ctrl_test;

  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [1:0]    cfg_wr_data;
  logic [1:0]    pwr_state;
  logic          mem_en;
  logic [1:0]    link_pm;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          m_valid;
  logic          m_ready;
  logic [DW-1:0] m_data;
  logic          mstandby;
  logic          mwait;
  logic          mwakeup;
  logic          ovf_err;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  mstby_ctrl #(.DATA_W(DW), .PS_W(2)) uut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] v);
    cfg_wr_en = 1'b1;
    cfg_wr_data = v;
    tick();
    cfg_wr_en = 1'b0;
    tick();
  endtask

  function automatic bit smart_exp(input logic [1:0] ps, input logic en);
    return !(ps == 2'd0 && en);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] seq;
    logic [DW-1:0] prev_d;
    bit            prev_hold;
    int unsigned   s;
    s = $urandom(32'd2024);
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = 2'd0;
    pwr_state = 2'd3; mem_en = 1'b0; link_pm = 2'd0;
    in_valid = 1'b0; in_data = '0; m_ready = 1'b0; mwait = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk(mstandby == 1'b1, "R1 mstandby", mstandby, 1);
    chk(!m_valid && !mwakeup && !ovf_err, "R1 outputs low", {m_valid, mwakeup, ovf_err}, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

    // R3 smart, one-edge latency
    pwr_state = 2'd0; mem_en = 1'b1;
    #1 chk(mstandby == 1'b1, "R3 before edge", mstandby, 1);
    tick();
    chk(mstandby == 1'b0, "R3 D0+mem", mstandby, 0);
    for (int i = 0; i < 4; i++) begin
      link_pm = 2'(i);
      tick();
      chk(mstandby == 1'b0, "R4 link state", mstandby, 0);
    end
    for (int i = 0; i < 8; i++) begin
      pwr_state = 2'(i >> 1); mem_en = i[0];
      tick();
      chk(mstandby == smart_exp(pwr_state, mem_en), "R3 sweep", mstandby, smart_exp(pwr_state, mem_en));
    end

    // R2 modes
    pwr_state = 2'd3; mem_en = 1'b0;
    tick();
    wr_mode(2'd1);
    chk(mstandby == 1'b0, "R2 none", mstandby, 0);
    pwr_state = 2'd0; mem_en = 1'b1;
    wr_mode(2'd0);
    chk(mstandby == 1'b1, "R2 force", mstandby, 1);
    wr_mode(2'd3);
    chk(mstandby == 1'b0, "R2 reserved as smart awake", mstandby, 0);
    mem_en = 1'b0;
    tick();
    chk(mstandby == 1'b1, "R2 reserved as smart asleep", mstandby, 1);
    wr_mode(2'd2);
    chk(mstandby == 1'b1, "R2 smart", mstandby, 1);

    // R5 / R7 park and overflow
    in_valid = 1'b1; in_data = 32'hA5A5_0001;
    #1 chk(in_ready == 1'b1, "R5 slot empty", in_ready, 1);
    tick();
    in_valid = 1'b0;
    tick();
    chk(mstandby == 1'b1, "R5 no wake by request", mstandby, 1);
    chk(m_valid == 1'b0, "R6 gated in standby", m_valid, 0);
    chk(mwakeup == 1'b1, "R5 mwakeup", mwakeup, 1);
    in_valid = 1'b1; in_data = 32'hBBBB_0002;
    #1 chk(in_ready == 1'b0, "R7 slot full", in_ready, 0);
    tick();
    in_valid = 1'b0;
    chk(ovf_err == 1'b1, "R7 ovf pulse", ovf_err, 1);
    tick();
    chk(ovf_err == 1'b0, "R7 ovf one cycle", ovf_err, 0);

    // R6 / R8 / R10 gating and outstanding
    mem_en = 1'b1;
    tick();
    chk(mstandby == 1'b0, "R6 awake", mstandby, 0);
    chk(mwakeup == 1'b0, "R5 mwakeup clears", mwakeup, 0);
    chk(m_valid == 1'b0, "R6 gated by mwait", m_valid, 0);
    mwait = 1'b0;
    #1 chk(m_valid == 1'b1 && m_data == 32'hA5A5_0001, "R6 delivered data", m_data, 32'hA5A5_0001);
    mem_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(mstandby == 1'b0, "R8 held out of standby", mstandby, 0);
      chk(m_valid && m_data == 32'hA5A5_0001, "R10 held stable", m_data, 32'hA5A5_0001);
    end
    m_ready = 1'b1;
    tick();
    m_ready = 1'b0;
    #1 chk(m_valid == 1'b0 && mstandby == 1'b0, "R8 accept edge", {m_valid, mstandby}, 0);
    tick();
    chk(mstandby == 1'b1, "R8 standby after accept", mstandby, 1);
    mwait = 1'b1;

    // R9 / R10 random traffic in no-standby
    wr_mode(2'd1);
    mwait = 1'b0;
    seq = 32'h100;
    prev_hold = 1'b0;
    prev_d = '0;
    for (int i = 0; i < 400; i++) begin
      m_ready = ($urandom % 4) != 0;
      #1;
      if (in_ready && ($urandom % 3 != 0)) begin
        in_valid = 1'b1; in_data = seq;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (prev_hold) chk(m_valid && m_data == prev_d, "R10 hold", m_data, prev_d);
      if (m_valid && m_ready) chk(in_ready == 1'b1, "R9 refill", in_ready, 1);
      if (in_valid && in_ready) begin
        exp_q.push_back(in_data);
        seq++;
      end
      if (m_valid && m_ready) begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(m_data == e, "R10 order", m_data, e);
      end
      prev_hold = m_valid && !m_ready;
      prev_d = m_data;
      tick();
    end
    in_valid = 1'b0;
    m_ready = 1'b1;
    if (m_valid) begin
      logic [DW-1:0] e;
      e = exp_q.pop_front();
      chk(m_data == e, "R10 last", m_data, e);
    end
    tick();
    m_ready = 1'b0;
    chk(exp_q.size() == 0 && !m_valid, "R10 drained", exp_q.size(), 0);

    // R3 / R4 random smart
    wr_mode(2'd2);
    for (int i = 0; i < 200; i++) begin
      pwr_state = 2'($urandom % 4);
      mem_en    = 1'($urandom % 2);
      link_pm   = 2'($urandom % 4);
      tick();
      chk(mstandby == smart_exp(pwr_state, mem_en), "R3 random smart", mstandby, smart_exp(pwr_state, mem_en));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule